// File: doc/BRIEF.md
# Electron/Photon Candidate Builder

This block judges whether the centre of a 5x5 window of calorimeter towers seeds an electron or photon candidate. Every tower in the window brings an electromagnetic transverse energy (EM ET) value and two pass bits. One pass bit says the tower's hadronic-to-EM energy ratio is small enough. The other says its shower shape is narrow, meaning two neighbouring crystal strips carry more than 90% of the tower energy. The block accepts one window per clock and, two cycles later, presents a candidate flag, a rank and an isolation flag.

The rank adds the centre energy to the energy of its strongest edge neighbour. The isolation flag needs two things: every tower touching the centre must be clean, and at least one of the four L-shaped corner regions must be quiet when compared with a threshold taken from a port. Towers are numbered `r*5+c`, where row r=0 is the top row and column c=0 is the left column. The centre is tower 12. Tower i occupies bits `[i*ET_W +: ET_W]` of the energy bus and bit i of each pass-bit bus.

Top module: `eg_cand_builder`

## Requirements
- R1: `out_valid` is high only when `in_valid` was high two cycles earlier and the ratio pass bit of tower 12 was set in that same window.
- R2: `out_valid` also requires that the shape pass bit of tower 12 was set in that window. When `in_valid`, the ratio bit and the shape bit of tower 12 are all set, `out_valid` is 1.
- R3: When `out_valid` is 1, `out_rank` equals the EM ET of tower 12 plus the largest EM ET among towers 7, 11, 13 and 17. The diagonal towers never enter the rank.
- R4: The rank saturates at 2^RANK_W-1 and never wraps.
- R5: While `out_valid` is 0, `out_rank` is 0.
- R6: `out_iso` requires both pass bits to be set on all eight towers 6, 7, 8, 11, 13, 16, 17 and 18. The pass bits of the outer ring towers do not affect isolation.
- R7: `out_iso` also requires at least one corner group whose EM ET sum is strictly less than `iso_thresh`. The corner groups are: {6,1,5,2,10}, {8,3,9,2,14}, {16,21,15,22,10} and {18,23,19,22,14}.
- R8: `out_iso` is 0 whenever `out_valid` is 0.
- R9: The latency is fixed at two clock cycles, and a new window is accepted every cycle with no gaps. Each output relates only to the window it was computed from.
- R10: While `rst` is high, and in the cycle after it, `out_valid`, `out_rank` and `out_iso` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window on the input buses is valid |
| win_et | input | 25*ET_W (200) | EM ET per tower, tower i at `[i*ET_W +: ET_W]` |
| win_ratio_ok | input | 25 | Per-tower hadronic-to-EM ratio pass bit |
| win_fg_ok | input | 25 | Per-tower shower-shape pass bit |
| iso_thresh | input | ISO_W (11) | Corner-group quiet threshold (strict less-than) |
| out_valid | output | 1 | Centre is a hit on a valid window |
| out_rank | output | RANK_W (9) | Saturated candidate rank |
| out_iso | output | 1 | Candidate is isolated |

## Verification
The bench builds the block with ET_W=8, RANK_W=8 and ISO_W=11. With RANK_W equal to ET_W, the sum of two strong towers goes past the rank range, so saturation (R4) can be reached, which the default 9-bit rank never allows. An 11-bit threshold covers every possible five-tower corner sum, so the bench can test the boundary where a corner sum equals the threshold. Random windows are biased toward centres that pass and toward corners with low energy, so the hit and isolation paths are exercised often.

// File: rtl/eg_cand_pkg.sv
package eg_cand_pkg;

    localparam int WIN_DIM   = 5;
    localparam int N_TWR     = WIN_DIM * WIN_DIM;
    localparam int CTR_ROW   = WIN_DIM / 2;
    localparam int CTR_IDX   = CTR_ROW * WIN_DIM + CTR_ROW;
    localparam int N_EDGE    = 4;
    localparam int N_CORNER  = 4;
    localparam int CORNER_SZ = 5;

    typedef struct packed {
        logic                valid;
        logic                hit;
        logic                clean;
        logic [N_CORNER-1:0] quiet;
    } eg_flags_t;

    function automatic int tower_at(input int r, input int c);
        return r * WIN_DIM + c;
    endfunction

    // Edge neighbours: 0 north, 1 south, 2 west, 3 east
    function automatic int edge_idx(input int k);
        case (k)
            0:       return tower_at(CTR_ROW - 1, CTR_ROW);
            1:       return tower_at(CTR_ROW + 1, CTR_ROW);
            2:       return tower_at(CTR_ROW, CTR_ROW - 1);
            default: return tower_at(CTR_ROW, CTR_ROW + 1);
        endcase
    endfunction

    // Corner k: bit1 picks south, bit0 picks east. Member j walks the L.
    function automatic int corner_idx(input int k, input int j);
        int dr;
        int dc;
        dr = ((k / 2) % 2 == 1) ? 1 : -1;
        dc = (k % 2 == 1) ? 1 : -1;
        case (j)
            0:       return tower_at(CTR_ROW + dr,     CTR_ROW + dc);
            1:       return tower_at(CTR_ROW + 2 * dr, CTR_ROW + dc);
            2:       return tower_at(CTR_ROW + dr,     CTR_ROW + 2 * dc);
            3:       return tower_at(CTR_ROW + 2 * dr, CTR_ROW);
            default: return tower_at(CTR_ROW,          CTR_ROW + 2 * dc);
        endcase
    endfunction

    // The eight towers touching the centre
    function automatic logic [N_TWR-1:0] ring_mask();
        logic [N_TWR-1:0] m;
        m = '0;
        for (int r = CTR_ROW - 1; r <= CTR_ROW + 1; r++) begin
            for (int c = CTR_ROW - 1; c <= CTR_ROW + 1; c++) begin
                if (tower_at(r, c) != CTR_IDX) begin
                    m[tower_at(r, c)] = 1'b1;
                end
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/eg_seed_eval.sv
module eg_seed_eval
    import eg_cand_pkg::*;
#(
    parameter int ET_W = 8
) (
    input  logic [N_TWR*ET_W-1:0] et,
    input  logic [N_TWR-1:0]      ratio_ok,
    input  logic [N_TWR-1:0]      fg_ok,
    output logic                  hit,
    output logic [ET_W-1:0]       centre_et,
    output logic [ET_W-1:0]       edge_max
);

    logic [ET_W-1:0] edge_et [N_EDGE];
    logic [ET_W-1:0] vert_max;
    logic [ET_W-1:0] horz_max;

    generate
        for (genvar k = 0; k < N_EDGE; k++) begin : g_edge
            assign edge_et[k] = et[edge_idx(k)*ET_W +: ET_W];
        end
    endgenerate

    // Two-level compare tree: vertical pair, horizontal pair, then winner
    always_comb begin
        vert_max = (edge_et[0] >= edge_et[1]) ? edge_et[0] : edge_et[1];
        horz_max = (edge_et[2] >= edge_et[3]) ? edge_et[2] : edge_et[3];
        edge_max = (vert_max >= horz_max) ? vert_max : horz_max;
    end

    assign centre_et = et[CTR_IDX*ET_W +: ET_W];
    assign hit       = ratio_ok[CTR_IDX] & fg_ok[CTR_IDX];

endmodule

// File: rtl/eg_iso_eval.sv
module eg_iso_eval
    import eg_cand_pkg::*;
#(
    parameter int ET_W  = 8,
    parameter int ISO_W = 11
) (
    input  logic [N_TWR*ET_W-1:0] et,
    input  logic [N_TWR-1:0]      ratio_ok,
    input  logic [N_TWR-1:0]      fg_ok,
    input  logic [ISO_W-1:0]      thresh,
    output logic                  clean,
    output logic [N_CORNER-1:0]   quiet
);

    localparam int GSUM_W = ET_W + $clog2(CORNER_SZ);
    localparam int CMP_W  = (GSUM_W > ISO_W) ? GSUM_W : ISO_W;
    localparam logic [N_TWR-1:0] RING = ring_mask();

    logic [N_TWR-1:0] pass_both;

    assign pass_both = ratio_ok & fg_ok;
    assign clean     = &(pass_both | ~RING);

    generate
        for (genvar k = 0; k < N_CORNER; k++) begin : g_corner
            logic [GSUM_W-1:0] grp_sum;
            always_comb begin
                grp_sum = '0;
                for (int j = 0; j < CORNER_SZ; j++) begin
                    grp_sum = grp_sum + GSUM_W'(et[corner_idx(k, j)*ET_W +: ET_W]);
                end
            end
            assign quiet[k] = CMP_W'(grp_sum) < CMP_W'(thresh);
        end
    endgenerate

endmodule

// File: rtl/eg_rank_stage.sv
module eg_rank_stage
    import eg_cand_pkg::*;
#(
    parameter int ET_W   = 8,
    parameter int RANK_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  eg_flags_t         flags_q,
    input  logic [ET_W-1:0]   centre_q,
    input  logic [ET_W-1:0]   edge_q,
    output logic              cand_valid,
    output logic [RANK_W-1:0] cand_rank,
    output logic              cand_iso
);

    localparam int SUM_W = ET_W + 1;

    logic [SUM_W-1:0]  raw_sum;
    logic [RANK_W-1:0] sat_sum;
    logic              valid_n;
    logic              iso_n;

    assign raw_sum = SUM_W'(centre_q) + SUM_W'(edge_q);

    generate
        if (RANK_W >= SUM_W) begin : g_wide
            assign sat_sum = RANK_W'(raw_sum);
        end else begin : g_clamp
            localparam logic [SUM_W-1:0] CAP = SUM_W'((1 << RANK_W) - 1);
            assign sat_sum = (raw_sum > CAP) ? '1 : raw_sum[RANK_W-1:0];
        end
    endgenerate

    assign valid_n = flags_q.valid & flags_q.hit;
    assign iso_n   = valid_n & flags_q.clean & (|flags_q.quiet);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_valid <= 1'b0;
            cand_rank  <= '0;
            cand_iso   <= 1'b0;
        end else begin
            cand_valid <= valid_n;
            cand_rank  <= valid_n ? sat_sum : '0;
            cand_iso   <= iso_n;
        end
    end

endmodule

// File: rtl/eg_cand_builder.sv
module eg_cand_builder
    import eg_cand_pkg::*;
#(
    parameter int ET_W   = 8,
    parameter int RANK_W = 9,
    parameter int ISO_W  = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [N_TWR*ET_W-1:0] win_et,
    input  logic [N_TWR-1:0]      win_ratio_ok,
    input  logic [N_TWR-1:0]      win_fg_ok,
    input  logic [ISO_W-1:0]      iso_thresh,
    output logic                  out_valid,
    output logic [RANK_W-1:0]     out_rank,
    output logic                  out_iso
);

    logic                hit_c;
    logic [ET_W-1:0]     centre_c;
    logic [ET_W-1:0]     edge_c;
    logic                clean_c;
    logic [N_CORNER-1:0] quiet_c;

    eg_flags_t           flags_q;
    logic [ET_W-1:0]     centre_q;
    logic [ET_W-1:0]     edge_q;

    eg_seed_eval #(.ET_W(ET_W)) u_seed (
        .et        (win_et),
        .ratio_ok  (win_ratio_ok),
        .fg_ok     (win_fg_ok),
        .hit       (hit_c),
        .centre_et (centre_c),
        .edge_max  (edge_c)
    );

    eg_iso_eval #(.ET_W(ET_W), .ISO_W(ISO_W)) u_iso (
        .et       (win_et),
        .ratio_ok (win_ratio_ok),
        .fg_ok    (win_fg_ok),
        .thresh   (iso_thresh),
        .clean    (clean_c),
        .quiet    (quiet_c)
    );

    // Stage 1: register seed and isolation decisions
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            centre_q <= '0;
            edge_q   <= '0;
        end else begin
            flags_q.valid <= in_valid;
            flags_q.hit   <= hit_c;
            flags_q.clean <= clean_c;
            flags_q.quiet <= quiet_c;
            centre_q      <= centre_c;
            edge_q        <= edge_c;
        end
    end

    // Stage 2: rank saturation and output qualification
    eg_rank_stage #(.ET_W(ET_W), .RANK_W(RANK_W)) u_rank (
        .clk        (clk),
        .rst        (rst),
        .flags_q    (flags_q),
        .centre_q   (centre_q),
        .edge_q     (edge_q),
        .cand_valid (out_valid),
        .cand_rank  (out_rank),
        .cand_iso   (out_iso)
    );

endmodule

// File: rtl/eg_cand_checker.sv
module eg_cand_checker
    import eg_cand_pkg::*;
#(
    parameter int ET_W   = 8,
    parameter int RANK_W = 9,
    parameter int ISO_W  = 11
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [N_TWR*ET_W-1:0] win_et,
    input logic [N_TWR-1:0]      win_ratio_ok,
    input logic [N_TWR-1:0]      win_fg_ok,
    input logic [ISO_W-1:0]      iso_thresh,
    input logic                  out_valid,
    input logic [RANK_W-1:0]     out_rank,
    input logic                  out_iso
);

    localparam int CW = RANK_W + ET_W;
    localparam logic [N_TWR-1:0] RING = ring_mask();

    p_valid_ratio_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid, 2) && $past(win_ratio_ok[CTR_IDX], 2)));

    p_valid_shape_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(win_fg_ok[CTR_IDX], 2));

    p_rank_floor_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (CW'(out_rank) >= CW'($past(win_et[CTR_IDX*ET_W +: ET_W], 2))));

    p_rank_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_rank == '0));

    p_iso_ring_r6: assert property (@(posedge clk) disable iff (rst)
        out_iso |-> (($past(win_ratio_ok & win_fg_ok, 2) & RING) == RING));

    p_iso_hit_r8: assert property (@(posedge clk) disable iff (rst)
        out_iso |-> out_valid);

endmodule

bind eg_cand_builder eg_cand_checker #(
    .ET_W   (ET_W),
    .RANK_W (RANK_W),
    .ISO_W  (ISO_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .win_et       (win_et),
    .win_ratio_ok (win_ratio_ok),
    .win_fg_ok    (win_fg_ok),
    .iso_thresh   (iso_thresh),
    .out_valid    (out_valid),
    .out_rank     (out_rank),
    .out_iso      (out_iso)
);

// File: tb/tb_eg_cand_builder.sv
module tb_eg_cand_builder;

    localparam int CLK_P = 10;
    localparam int ET_W  = 8;
    localparam int RK_W  = 8;
    localparam int TH_W  = 11;
    localparam int NT    = 25;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [NT*ET_W-1:0] win_et = '0;
    logic [NT-1:0]      win_ratio_ok = '0;
    logic [NT-1:0]      win_fg_ok = '0;
    logic [TH_W-1:0]    iso_thresh = '0;
    logic               out_valid;
    logic [RK_W-1:0]    out_rank;
    logic               out_iso;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [NT*ET_W-1:0] w_et;
    logic [NT-1:0]      w_ra;
    logic [NT-1:0]      w_fg;
    logic [TH_W-1:0]    w_thr;

    logic            pv [2];
    logic [RK_W-1:0] pr [2];
    logic            pi [2];
    string           pt [2];

    always #(CLK_P/2) clk = ~clk;

    eg_cand_builder #(.ET_W(ET_W), .RANK_W(RK_W), .ISO_W(TH_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .win_et       (win_et),
        .win_ratio_ok (win_ratio_ok),
        .win_fg_ok    (win_fg_ok),
        .iso_thresh   (iso_thresh),
        .out_valid    (out_valid),
        .out_rank     (out_rank),
        .out_iso      (out_iso)
    );

    function automatic int et_of(input logic [NT*ET_W-1:0] e, input int i);
        return int'(e[i*ET_W +: ET_W]);
    endfunction

    // Reference model written from the requirements
    function automatic void model(input logic v, input logic [NT*ET_W-1:0] e,
                                  input logic [NT-1:0] ra, input logic [NT-1:0] fg,
                                  input logic [TH_W-1:0] thr, output logic ov,
                                  output logic [RK_W-1:0] orank, output logic oiso);
        int edges [4] = '{7, 17, 11, 13};
        int ring  [8] = '{6, 7, 8, 11, 13, 16, 17, 18};
        int grp   [4][5] = '{'{6, 1, 5, 2, 10}, '{8, 3, 9, 2, 14},
                             '{16, 21, 15, 22, 10}, '{18, 23, 19, 22, 14}};
        int m;
        int s;
        int gs;
        bit cl;
        bit q;
        ov = v & ra[12] & fg[12];
        m = 0;
        foreach (edges[k]) if (et_of(e, edges[k]) > m) m = et_of(e, edges[k]);
        s = et_of(e, 12) + m;
        if (s > (1 << RK_W) - 1) s = (1 << RK_W) - 1;
        orank = ov ? RK_W'(s) : '0;
        cl = 1'b1;
        foreach (ring[k]) cl = cl & ra[ring[k]] & fg[ring[k]];
        q = 1'b0;
        for (int g = 0; g < 4; g++) begin
            gs = 0;
            for (int j = 0; j < 5; j++) gs += et_of(e, grp[g][j]);
            if (gs < int'(thr)) q = 1'b1;
        end
        oiso = ov & cl & q;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_et(input int i, input int v);
        w_et[i*ET_W +: ET_W] = ET_W'(v);
    endtask

    task automatic base();
        for (int i = 0; i < NT; i++) set_et(i, 2);
        w_ra  = '1;
        w_fg  = '1;
        w_thr = TH_W'(100);
    endtask

    // One cycle: check the window of two cycles ago, then drive a new one
    task automatic step(input logic v, input string tag);
        logic            ev;
        logic [RK_W-1:0] er;
        logic            ei;
        @(negedge clk);
        chk(pt[1], "valid", int'(out_valid), int'(pv[1]));
        chk(pt[1], "rank",  int'(out_rank),  int'(pr[1]));
        chk(pt[1], "iso",   int'(out_iso),   int'(pi[1]));
        pv[1] = pv[0]; pr[1] = pr[0]; pi[1] = pi[0]; pt[1] = pt[0];
        model(v, w_et, w_ra, w_fg, w_thr, ev, er, ei);
        pv[0] = ev; pr[0] = er; pi[0] = ei; pt[0] = tag;
        in_valid     = v;
        win_et       = w_et;
        win_ratio_ok = w_ra;
        win_fg_ok    = w_fg;
        iso_thresh   = w_thr;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL R9 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int k = 0; k < 2; k++) begin
            pv[k] = 1'b0; pr[k] = '0; pi[k] = 1'b0; pt[k] = "R10";
        end
        base();
        win_et = '1; win_ratio_ok = '1; win_fg_ok = '1;
        repeat (3) @(negedge clk);
        // R10: outputs held at zero during reset
        chk("R10", "valid", int'(out_valid), 0);
        chk("R10", "rank",  int'(out_rank),  0);
        chk("R10", "iso",   int'(out_iso),   0);
        rst = 1'b0;
        in_valid = 1'b0;

        // R1: ratio bit of centre cleared
        base(); w_ra[12] = 1'b0; step(1'b1, "R1");
        // R2: shape bit of centre cleared
        base(); w_fg[12] = 1'b0; step(1'b1, "R2");
        // R3: edges only, large diagonal ignored, expect 40+30
        base(); set_et(12, 40); set_et(7, 10); set_et(17, 20); set_et(11, 30);
        set_et(13, 5); set_et(6, 200); set_et(18, 220); step(1'b1, "R3");
        // R4: 200+200 saturates at 255
        base(); set_et(12, 200); set_et(13, 200); step(1'b1, "R4");
        // R5: hit window but not valid
        base(); set_et(12, 90); step(1'b0, "R5");
        // R6: ring cleanliness
        base(); step(1'b1, "R6");
        base(); w_fg[18] = 1'b0; step(1'b1, "R6");
        base(); w_ra[7] = 1'b0; step(1'b1, "R6");
        base(); w_fg[0] = 1'b0; w_ra[24] = 1'b0; step(1'b1, "R6");
        // R7: one quiet corner suffices, none fails, equality is not quiet
        base(); set_et(1, 200); set_et(3, 200); set_et(21, 200); step(1'b1, "R7");
        base(); set_et(1, 200); set_et(3, 200); set_et(21, 200); set_et(23, 200);
        step(1'b1, "R7");
        base(); w_thr = TH_W'(10); step(1'b1, "R7");
        base(); w_thr = TH_W'(11); step(1'b1, "R7");
        // R8: isolated surroundings but centre not a hit
        base(); w_ra[12] = 1'b0; step(1'b1, "R8");
        base(); step(1'b0, "R8");

        // R9: back-to-back random windows
        for (int n = 0; n < 3000; n++) begin
            bit lowband;
            lowband = ($urandom_range(0, 1) == 1);
            for (int i = 0; i < NT; i++) begin
                set_et(i, lowband ? $urandom_range(0, 15) : $urandom_range(0, 255));
                w_ra[i] = ($urandom_range(0, 15) != 0);
                w_fg[i] = ($urandom_range(0, 15) != 0);
            end
            w_thr = TH_W'($urandom_range(0, 700));
            step(($urandom_range(0, 7) != 0), "R9");
        end
        base();
        step(1'b0, "R9");
        step(1'b0, "R9");
        step(1'b0, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule